// File: doc/BRIEF.md
# Four-Phase Register Move Unit

This block is a small execution slice of an 8-bit controller core. It accepts one 16-bit instruction word per instruction cycle and runs it against a 256-byte register file. It executes two instructions. The first copies any register into a register in the low 32-address window. The second loads a 4-bit literal into the low nibble of an 8-bit bank register and leaves that register's upper nibble untouched.

Each instruction cycle is four clocks long. A free-running phase counter steps through decode, read, execute and write. The instruction word is captured at the end of the decode phase, and the source register is read at the end of the read phase. The operand is latched at the end of the execute phase, and the destination is written at the end of the write phase. A one-clock done strobe then marks the end of the instruction.

The working register and the bank register live at fixed register-file addresses, so a move can read or write either one. Their current values are driven on dedicated outputs. A peripheral-side write port and a registered read port connect the register file to the rest of the chip.

Top module: `regmove_unit`

## Requirements
- R1: A synchronous active-high reset puts the phase counter in the decode phase, clears every register-file location (including the bank register at 0Fh and the working register at 0Ah) to 00h, and drives done and the read-port data to 0.
- R2: The instruction word is sampled only at the clock edge that ends the decode phase. Changes on the instruction input during the read, execute and write phases have no effect.
- R3: A word with bits 15:13 = 011 is a move: bits 12:8 give the destination address 00h–1Fh and bits 7:0 give the source address 00h–FFh. Afterwards the destination holds the source's value and the source is unchanged (for example, source 33h and destination 11h both end at 33h).
- R4: The move's destination is written only at the clock edge that ends the write phase. Before that edge it still reads its old value.
- R5: A word with bits 15:8 = B8h is a bank literal load. Bits 3:0 replace bank register bits 3:0 and bank bits 7:4 keep their value (for example, 22h with literal 5 becomes 25h). Instruction bits 7:4 are ignored.
- R6: The working register is register-file address 0Ah and the bank register is address 0Fh. A move may use either as source or destination, and the working-register and bank outputs follow every write to those addresses.
- R7: Any other word is a no-operation. It takes the full four phases, raises done, and changes no register.
- R8: Done is high for exactly one clock in every four: the clock after the write-phase edge.
- R9: The peripheral write port writes its data at the next clock edge, except at a write-phase edge where the instruction writes a register. At that edge the peripheral write is dropped.
- R10: The read port returns, one clock after the address is presented, the register contents as they stood before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word, sampled at the end of the decode phase |
| ext_we_i | input | 1 | Peripheral write enable |
| ext_addr_i | input | 8 | Peripheral write address |
| ext_data_i | input | 8 | Peripheral write data |
| rd_addr_i | input | 8 | Read port address |
| rd_data_o | output | 8 | Registered read port data |
| wreg_o | output | 8 | Current working register (address 0Ah) |
| bsr_o | output | 8 | Current bank register (address 0Fh) |
| done_o | output | 1 | One-clock strobe after each instruction's write phase |

## Verification
An instruction word presented in the clock before a decode-phase edge reaches the register file four edges later. Its result shows on the working-register and bank outputs and on done in the clock after that write-phase edge, and on the read port one clock later still. The bench's reference model advances once per rising edge. It reads before it writes, as the hardware does, and all outputs are compared on the falling edge. Directed checks wait for the model's decode phase before they drive a word, so each check samples exactly the cycle in which its result is due. That includes the write-phase clock, where the destination must still hold its old value.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

  localparam int INSTR_W = 16;
  localparam int SRC_W   = 8;
  localparam int DST_W   = 5;
  localparam int LIT_W   = 4;

  localparam logic [2:0] MOVE_OPC = 3'b011;
  localparam logic [7:0] LITB_OPC = 8'hB8;

  typedef enum logic [1:0] {
    PH_DEC = 2'd0,
    PH_RD  = 2'd1,
    PH_EX  = 2'd2,
    PH_WR  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_MOVE = 2'd1,
    OP_LITB = 2'd2
  } op_t;

  typedef struct packed {
    op_t              op;
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic [LIT_W-1:0] lit;
  } dec_t;

endpackage

// File: rtl/rm_phase_seq.sv
module rm_phase_seq
  import regmove_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t ph_o,
  output logic   done_o
);

  phase_t ph_q;
  logic   done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_DEC;
      done_q <= 1'b0;
    end else begin
      ph_q   <= phase_t'(ph_q + 2'd1);
      done_q <= (ph_q == PH_WR);
    end
  end

  assign ph_o   = ph_q;
  assign done_o = done_q;

  assert_phase_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ph_o == phase_t'($past(ph_o) + 2'd1));

  assert_done_align_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ph_o == PH_DEC);

endmodule

// File: rtl/rm_decode.sv
module rm_decode
  import regmove_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  phase_t             ph_i,
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  logic [INSTR_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst)
      ir_q <= '0;
    else if (ph_i == PH_DEC)
      ir_q <= instr_i;
  end

  always_comb begin
    dec_o.src = ir_q[SRC_W-1:0];
    dec_o.dst = ir_q[SRC_W +: DST_W];
    dec_o.lit = ir_q[LIT_W-1:0];
    if (ir_q[INSTR_W-1 -: 3] == MOVE_OPC)
      dec_o.op = OP_MOVE;
    else if (ir_q[INSTR_W-1 -: 8] == LITB_OPC)
      dec_o.op = OP_LITB;
    else
      dec_o.op = OP_NOP;
  end

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ph_i != PH_DEC) |=> $stable(ir_q));

endmodule

// File: rtl/rm_regfile.sv
module rm_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ra_q, rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      ra_q <= mem[ra_addr_i];
      rb_q <= mem[rb_addr_i];
    end
  end

  assign ra_data_o = ra_q;
  assign rb_data_o = rb_q;

endmodule

// File: rtl/rm_mirror.sv
module rm_mirror #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HOME = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we_i && waddr_i == HOME)
      q <= wdata_i;
  end

  assign q_o = q;

endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
  import regmove_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] WREG_ADDR = 8'h0A,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'h0F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               ext_we_i,
  input  logic [ADDR_W-1:0]  ext_addr_i,
  input  logic [DATA_W-1:0]  ext_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [DATA_W-1:0]  wreg_o,
  output logic [DATA_W-1:0]  bsr_o,
  output logic               done_o
);

  localparam int N_MIR = 2;
  localparam logic [N_MIR*ADDR_W-1:0] MIR_ADDRS = {BANK_ADDR, WREG_ADDR};

  phase_t            ph;
  dec_t              dec;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] result_q;
  logic              core_we;
  logic [ADDR_W-1:0] core_waddr;
  logic [DATA_W-1:0] core_wdata;
  logic              rf_we;
  logic [ADDR_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] mir_q [N_MIR];

  rm_phase_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .ph_o   (ph),
    .done_o (done_o)
  );

  rm_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .ph_i    (ph),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // execute phase: latch the operand fetched during the read phase
  always_ff @(posedge clk) begin
    if (rst)
      result_q <= '0;
    else if (ph == PH_EX)
      result_q <= opnd;
  end

  always_comb begin
    core_we    = (ph == PH_WR) && (dec.op != OP_NOP);
    core_waddr = BANK_ADDR;
    core_wdata = {bsr_o[DATA_W-1:LIT_W], dec.lit};
    if (dec.op == OP_MOVE) begin
      core_waddr = ADDR_W'(dec.dst);
      core_wdata = result_q;
    end
  end

  // one write port: the instruction owns it in its write phase
  always_comb begin
    rf_we    = core_we | ext_we_i;
    rf_waddr = core_we ? core_waddr : ext_addr_i;
    rf_wdata = core_we ? core_wdata : ext_data_i;
  end

  rm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .ra_addr_i (ADDR_W'(dec.src)),
    .ra_data_o (opnd),
    .rb_addr_i (rd_addr_i),
    .rb_data_o (rd_data_o)
  );

  for (genvar g = 0; g < N_MIR; g++) begin : g_mir
    rm_mirror #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .HOME   (MIR_ADDRS[g*ADDR_W +: ADDR_W])
    ) u_mir (
      .clk     (clk),
      .rst     (rst),
      .we_i    (rf_we),
      .waddr_i (rf_waddr),
      .wdata_i (rf_wdata),
      .q_o     (mir_q[g])
    );
  end

  assign wreg_o = mir_q[0];
  assign bsr_o  = mir_q[1];

  assert_lit_keeps_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WR && dec.op == OP_LITB) |=> bsr_o[DATA_W-1:LIT_W] == $past(bsr_o[DATA_W-1:LIT_W]));

  assert_lit_sets_low_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WR && dec.op == OP_LITB) |=> bsr_o[LIT_W-1:0] == $past(dec.lit));

  assert_nop_no_change_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WR && dec.op == OP_NOP && !ext_we_i) |=> ($stable(bsr_o) && $stable(wreg_o)));

  assert_move_to_wreg_R6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WR && dec.op == OP_MOVE && ADDR_W'(dec.dst) == WREG_ADDR) |=> wreg_o == $past(result_q));

endmodule

// File: tb/regmove_unit_tb.sv
module regmove_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr_i;
  logic        ext_we_i;
  logic [7:0]  ext_addr_i, ext_data_i, rd_addr_i;
  logic [7:0]  rd_data_o, wreg_o, bsr_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  regmove_unit u_dut (
    .clk (clk), .rst (rst), .instr_i (instr_i),
    .ext_we_i (ext_we_i), .ext_addr_i (ext_addr_i), .ext_data_i (ext_data_i),
    .rd_addr_i (rd_addr_i), .rd_data_o (rd_data_o),
    .wreg_o (wreg_o), .bsr_o (bsr_o), .done_o (done_o)
  );

  // behavioural reference model
  int          m_ph;
  logic [7:0]  m_mem [256];
  logic [15:0] m_ir;
  logic [7:0]  m_opnd, m_res, m_rd;
  logic        m_done;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_done = 0; m_rd = 0; m_ir = 0; m_opnd = 0; m_res = 0;
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    end else begin
      logic [7:0] rd_next, wa, wd;
      bit cw;
      rd_next = m_mem[rd_addr_i];
      cw = 0; wa = 0; wd = 0;
      case (m_ph)
        0: m_ir = instr_i;
        1: m_opnd = m_mem[m_ir[7:0]];
        2: m_res = m_opnd;
        default: begin
          if (m_ir[15:13] == 3'b011) begin
            cw = 1; wa = {3'b000, m_ir[12:8]}; wd = m_res;
          end else if (m_ir[15:8] == 8'hB8) begin
            cw = 1; wa = 8'h0F; wd = {m_mem[15][7:4], m_ir[3:0]};
          end
        end
      endcase
      if (cw) m_mem[wa] = wd;
      else if (ext_we_i) m_mem[ext_addr_i] = ext_data_i;
      m_done = (m_ph == 3);
      m_ph = (m_ph + 1) % 4;
      m_rd = rd_next;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R8 done", {7'b0, done_o}, {7'b0, m_done});
      chk("R5 bank", bsr_o, m_mem[15]);
      chk("R6 wreg", wreg_o, m_mem[10]);
      chk("R10 read port", rd_data_o, m_rd);
    end
  end

  task automatic ext_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ext_we_i = 1; ext_addr_i = a; ext_data_i = d;
    @(negedge clk);
    ext_we_i = 0;
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    chk(tag, rd_data_o, exp);
  endtask

  task automatic wait_dec();
    @(negedge clk);
    while (m_ph != 0) @(negedge clk);
  endtask

  task automatic exec(input logic [15:0] w, input logic [15:0] junk);
    wait_dec();
    instr_i = w;
    repeat (3) begin @(negedge clk); instr_i = junk; end
    @(negedge clk);
    instr_i = 16'h0000;
    chk("R8 done after instruction", {7'b0, done_o}, 8'h01);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst = 1; instr_i = 0; ext_we_i = 0; ext_addr_i = 0; ext_data_i = 0; rd_addr_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 done", {7'b0, done_o}, 8'h00);
    chk("R1 bank", bsr_o, 8'h00);
    chk("R1 wreg", wreg_o, 8'h00);
    peek(8'h40, 8'h00, "R1 regfile cleared");

    // R9 peripheral writes
    ext_wr(8'h40, 8'h33);
    ext_wr(8'h05, 8'h11);
    peek(8'h05, 8'h11, "R9 peripheral write");

    // R3 move, R2 junk during later phases (junk would copy 40h to WREG)
    exec(16'h6540, 16'h6A40);
    peek(8'h05, 8'h33, "R3 destination");
    peek(8'h40, 8'h33, "R3 source kept");
    chk("R2 junk ignored", wreg_o, 8'h00);

    // R4 write timing and R10 read-before-write
    ext_wr(8'h06, 8'h11);
    rd_addr_i = 8'h06;
    wait_dec();
    instr_i = 16'h6640;
    @(negedge clk); instr_i = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    chk("R4 old value in write phase", rd_data_o, 8'h11);
    @(negedge clk);
    chk("R10 read at write edge sees old", rd_data_o, 8'h11);
    @(negedge clk);
    chk("R4 new value after write", rd_data_o, 8'h33);

    // R3 boundary: top source and top destination
    ext_wr(8'hFF, 8'hC3);
    exec(16'h7FFF, 16'h0000);
    peek(8'h1F, 8'hC3, "R3 boundary move");

    // R5 literal load
    ext_wr(8'h0F, 8'h22);
    chk("R5 bank preset", bsr_o, 8'h22);
    exec(16'hB8F5, 16'h0000);
    chk("R5 nibble load", bsr_o, 8'h25);
    exec(16'hB803, 16'h0000);
    chk("R5 second nibble load", bsr_o, 8'h23);

    // R6 working register as source and destination
    ext_wr(8'h0A, 8'h5A);
    chk("R6 wreg preset", wreg_o, 8'h5A);
    exec(16'h700A, 16'h0000);
    peek(8'h10, 8'h5A, "R6 wreg as source");
    exec(16'h6A40, 16'h0000);
    chk("R6 wreg as destination", wreg_o, 8'h33);

    // R7 no-operations
    exec(16'hB900, 16'h0000);
    exec(16'hC000, 16'h0000);
    exec(16'h4040, 16'h0000);
    chk("R7 bank unchanged", bsr_o, 8'h23);
    chk("R7 wreg unchanged", wreg_o, 8'h33);
    peek(8'h40, 8'h33, "R7 register unchanged");

    // R9 collision: peripheral write dropped at an instruction write edge
    wait_dec();
    instr_i = 16'h6740;
    @(negedge clk); instr_i = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    ext_we_i = 1; ext_addr_i = 8'h20; ext_data_i = 8'h99;
    @(negedge clk);
    ext_we_i = 0;
    peek(8'h20, 8'h00, "R9 dropped on collision");
    peek(8'h07, 8'h33, "R3 move during collision");

    // R8 strobe rate
    begin
      int n = 0;
      repeat (40) begin @(negedge clk); if (done_o) n++; end
      chk("R8 one done per four clocks", 8'(n), 8'd10);
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

endmodule